// File: doc/BRIEF.md
# Sample Clock Source Selector and Prescaler

This block produces the single-cycle sampling tick that paces audio capture and replay. It runs in the system clock domain and draws the tick from one of two sources. The first is an external clock pin, divided by a programmable integer N and then by a fixed base ratio of 128. The second is an internal rate generator that divides the system clock to one of four sampling rates. Which source is used is not programmed: the block watches the external pin, and while it toggles the pin wins. When it goes quiet the internal generator takes over.

Settings arrive as the 15-bit parameter word of a power-up command. Bits [1:0] carry a rate code and bits [9:2] carry the divider field. Bits [14:10] must be zero. A word that breaks a rule is dropped whole, and the previous setting stays in force.

A three-state machine governs the source. `ST_INT_RUN` means ticks come from the internal generator. `ST_INT_ARM` means external activity has been seen, but the block waits for the next internal tick. `ST_EXT_RUN` means ticks come from the prescaled external clock. The transitions are:
- Activity seen takes `ST_INT_RUN` to `ST_INT_ARM`.
- An internal tick while armed takes `ST_INT_ARM` to `ST_EXT_RUN`.
- Activity lost takes `ST_INT_ARM` back to `ST_INT_RUN`.
- Activity lost takes `ST_EXT_RUN` to `ST_INT_RUN`.

Top module: `sample_clock_gen`

## Requirements
- R1: While `ext_clk` toggles with an edge spacing below `LOSS_TIMEOUT` system clocks, `src_ext` becomes 1 and `sample_tick` is derived from `ext_clk`.
- R2: In internal mode, the rate code in `cfg_word[1:0]` sets the tick period to the matching parameter: 00 uses `INT_DIV_R0` (6.4 kHz), 01 uses `INT_DIV_R1` (4.0 kHz), 10 uses `INT_DIV_R2` (8.0 kHz) and 11 uses `INT_DIV_R3` (5.3 kHz) system clocks.
- R3: In external mode, ticks are spaced by exactly N × `BASE_DIV` rising edges of `ext_clk`, where N is the value of `cfg_word[9:2]`.
- R4: A divider field of 0 in `cfg_word[9:2]` means N = 256.
- R5: A word whose divider field `cfg_word[9:2]` equals 2 is rejected, and both the divider and the rate stay as before.
- R6: A word with any of `cfg_word[14:10]` set is rejected, and both the divider and the rate stay as before.
- R7: After reset `src_ext` is 0 and `sample_tick` is 0, and ticks come from the internal generator with rate code 00.
- R8: When no rising edge of `ext_clk` arrives for `LOSS_TIMEOUT` system clocks, `src_ext` falls. The first internal tick then follows a full internal period after the switch.
- R9: `sample_tick` is high for exactly one system clock per tick.
- R10: The change to the external source happens only in the cycle of an internal tick. The first external tick then needs a complete count of N × `BASE_DIV` edges, so no shortened tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk | input | 1 | External sample clock, asynchronous to `clk` |
| cfg_valid | input | 1 | One-cycle strobe marking `cfg_word` as a new setting |
| cfg_word | input | 15 | Parameter word of the power-up command: [14:10] must be zero, [9:2] holds the divider field, [1:0] holds the rate code |
| sample_tick | output | 1 | One-cycle sampling pulse |
| src_ext | output | 1 | 1 while the external source drives the tick |

## Verification
A stuck or wrong state shows up at the ports within one tick period. A wrong divider or rate register changes the spacing of the very next tick after the first one, so each setting is checked by measuring the gap between two consecutive ticks. A wrong source state shows on `src_ext`, and through the gap at the switchover. A late loss detection stretches the gap across the switch past timeout plus one internal period. A missing wait for the tick boundary shortens the gap at the switch to the external source.

// File: rtl/scg_pkg.sv
package scg_pkg;
    localparam int CFG_W  = 15;
    localparam int NDIV_W = 8;
    localparam int RATE_W = 2;
    localparam int NVAL_W = NDIV_W + 1;

    typedef enum logic [1:0] {
        ST_INT_RUN = 2'd0,
        ST_INT_ARM = 2'd1,
        ST_EXT_RUN = 2'd2
    } src_state_e;

    // divider field value 0 stands for the largest ratio
    function automatic logic [NVAL_W-1:0] ratio_of(input logic [NDIV_W-1:0] field);
        return (field == '0) ? NVAL_W'(1 << NDIV_W) : {1'b0, field};
    endfunction
endpackage

// File: rtl/scg_cfg.sv
module scg_cfg
    import scg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic [NDIV_W-1:0] n_field,
    output logic [RATE_W-1:0] rate_code,
    output logic              apply
);
    logic upper_ok;
    logic div_ok;

    always_comb begin
        upper_ok = (cfg_word[CFG_W-1:NDIV_W+RATE_W] == '0);
        div_ok   = (cfg_word[NDIV_W+RATE_W-1:RATE_W] != NDIV_W'(2));
        apply    = cfg_valid && upper_ok && div_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_field   <= NDIV_W'(1);
            rate_code <= '0;
        end else if (apply) begin
            n_field   <= cfg_word[NDIV_W+RATE_W-1:RATE_W];
            rate_code <= cfg_word[RATE_W-1:0];
        end
    end
endmodule

// File: rtl/scg_edge_mon.sv
module scg_edge_mon #(
    parameter int SYNC_STAGES  = 2,
    parameter int LOSS_TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic ext_rise,
    output logic ext_active
);
    localparam int IDLE_W = $clog2(LOSS_TIMEOUT + 1);

    logic [SYNC_STAGES:0] chain;
    logic [IDLE_W-1:0]    idle_cnt;

    genvar g;
    generate
        for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= ext_clk;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign ext_rise = chain[SYNC_STAGES-1] && !chain[SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt   <= '0;
            ext_active <= 1'b0;
        end else if (ext_rise) begin
            idle_cnt   <= '0;
            ext_active <= 1'b1;
        end else if (idle_cnt == IDLE_W'(LOSS_TIMEOUT - 1)) begin
            ext_active <= 1'b0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scg_ext_div.sv
module scg_ext_div
    import scg_pkg::*;
#(
    parameter int BASE_DIV = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ext_rise,
    input  logic [NDIV_W-1:0] n_field,
    output logic              ext_tick
);
    localparam int LIM_W = NVAL_W + $clog2(BASE_DIV) + 1;

    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] cnt;

    assign limit    = LIM_W'(ratio_of(n_field)) * LIM_W'(BASE_DIV);
    assign ext_tick = !clr && ext_rise && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (ext_tick)  cnt <= '0;
        else if (ext_rise)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/scg_int_div.sv
module scg_int_div
    import scg_pkg::*;
#(
    parameter int INT_DIV_R0 = 31250,
    parameter int INT_DIV_R1 = 50000,
    parameter int INT_DIV_R2 = 25000,
    parameter int INT_DIV_R3 = 37736
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate_code,
    output logic              int_tick
);
    localparam int MAX_A = (INT_DIV_R0 > INT_DIV_R1) ? INT_DIV_R0 : INT_DIV_R1;
    localparam int MAX_B = (INT_DIV_R2 > INT_DIV_R3) ? INT_DIV_R2 : INT_DIV_R3;
    localparam int MAX_P = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_P + 1);

    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        unique case (rate_code)
            2'b00: period = CNT_W'(INT_DIV_R0);
            2'b01: period = CNT_W'(INT_DIV_R1);
            2'b10: period = CNT_W'(INT_DIV_R2);
            2'b11: period = CNT_W'(INT_DIV_R3);
        endcase
    end

    assign int_tick = !clr && (cnt >= period - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (int_tick) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sample_clock_gen.sv
module sample_clock_gen
    import scg_pkg::*;
#(
    parameter int INT_DIV_R0   = 31250,
    parameter int INT_DIV_R1   = 50000,
    parameter int INT_DIV_R2   = 25000,
    parameter int INT_DIV_R3   = 37736,
    parameter int BASE_DIV     = 128,
    parameter int LOSS_TIMEOUT = 64,
    parameter int SYNC_STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_clk,
    input  logic        cfg_valid,
    input  logic [14:0] cfg_word,
    output logic        sample_tick,
    output logic        src_ext
);
    src_state_e        state_q, state_d;
    logic [NDIV_W-1:0] n_field;
    logic [RATE_W-1:0] rate_code;
    logic              apply;
    logic              ext_rise, ext_active;
    logic              ext_tick, int_tick;
    logic              ext_clr, int_clr;

    scg_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
        .n_field(n_field), .rate_code(rate_code), .apply(apply)
    );

    scg_edge_mon #(.SYNC_STAGES(SYNC_STAGES), .LOSS_TIMEOUT(LOSS_TIMEOUT)) u_mon (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
        .ext_rise(ext_rise), .ext_active(ext_active)
    );

    assign ext_clr = (state_q != ST_EXT_RUN) || apply;
    assign int_clr = (state_q == ST_EXT_RUN) || apply;

    scg_ext_div #(.BASE_DIV(BASE_DIV)) u_ext (
        .clk(clk), .rst_n(rst_n), .clr(ext_clr), .ext_rise(ext_rise),
        .n_field(n_field), .ext_tick(ext_tick)
    );

    scg_int_div #(
        .INT_DIV_R0(INT_DIV_R0), .INT_DIV_R1(INT_DIV_R1),
        .INT_DIV_R2(INT_DIV_R2), .INT_DIV_R3(INT_DIV_R3)
    ) u_int (
        .clk(clk), .rst_n(rst_n), .clr(int_clr),
        .rate_code(rate_code), .int_tick(int_tick)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INT_RUN: if (ext_active) state_d = ST_INT_ARM;
            ST_INT_ARM: begin
                if (!ext_active)   state_d = ST_INT_RUN;
                else if (int_tick) state_d = ST_EXT_RUN;
            end
            ST_EXT_RUN: if (!ext_active) state_d = ST_INT_RUN;
            default:    state_d = ST_INT_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INT_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                       sample_tick <= 1'b0;
        else if (state_q == ST_EXT_RUN)   sample_tick <= ext_tick;
        else                              sample_tick <= int_tick;
    end

    assign src_ext = (state_q == ST_EXT_RUN);
endmodule

// File: rtl/scg_checker.sv
module scg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_valid,
    input logic [14:0] cfg_word,
    input logic        sample_tick,
    input logic        src_ext,
    input logic        ext_active,
    input logic [7:0]  n_field,
    input logic [1:0]  rate_code
);
    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> !sample_tick); // R9

    AST_SWITCH_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_ext) |-> sample_tick); // R10

    AST_LOSS_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_active) |=> !src_ext); // R8

    AST_REJECT_RATIO_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_word[9:2] == 8'd2) |=> ($stable(n_field) && $stable(rate_code))); // R5

    AST_REJECT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_word[14:10] != 5'd0) |=> ($stable(n_field) && $stable(rate_code))); // R6
endmodule

bind sample_clock_gen scg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
    .sample_tick(sample_tick), .src_ext(src_ext), .ext_active(ext_active),
    .n_field(n_field), .rate_code(rate_code)
);

// File: tb/sample_clock_gen_test.sv
`timescale 1ns/1ps
module sample_clock_gen_test;
    localparam int P0 = 100, P1 = 160, P2 = 80, P3 = 120;
    localparam int BASE = 4, TMO = 64, EXT_CYC = 6;

    logic        clk = 0, rst_n = 0, ext_clk = 0, ext_en = 0;
    logic        cfg_valid = 0;
    logic [14:0] cfg_word = '0;
    logic        sample_tick, src_ext;
    int          cyc = 0, n_chk = 0, n_bad = 0;
    bit          done = 0;

    sample_clock_gen #(
        .INT_DIV_R0(P0), .INT_DIV_R1(P1), .INT_DIV_R2(P2), .INT_DIV_R3(P3),
        .BASE_DIV(BASE), .LOSS_TIMEOUT(TMO), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .cfg_valid(cfg_valid),
        .cfg_word(cfg_word), .sample_tick(sample_tick), .src_ext(src_ext)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        #1.3;
        forever begin
            #15;
            if (ext_en) ext_clk = ~ext_clk;
            else        ext_clk = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(input int lim, output bit ok);
        ok = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (sample_tick) begin ok = 1; return; end
        end
    endtask

    task automatic measure(input int lim, output int iv);
        bit ok; int t0;
        iv = -1;
        wait_tick(lim, ok); if (!ok) return;
        t0 = cyc;
        wait_tick(lim, ok); if (!ok) return;
        iv = cyc - t0;
    endtask

    task automatic send_cfg(input logic [14:0] w);
        @(negedge clk);
        cfg_valid = 1; cfg_word = w;
        @(negedge clk);
        cfg_valid = 0; cfg_word = '0;
    endtask

    task automatic t_reset;
        int iv;
        repeat (4) @(negedge clk);
        rst_n = 1;
        check(sample_tick == 0, "R7 tick after reset", sample_tick, 0);
        check(src_ext == 0, "R7 source after reset", src_ext, 0);
        measure(400, iv);
        check(iv == P0, "R7 default period", iv, P0);
    endtask

    task automatic t_rates;
        int iv;
        send_cfg({5'd0, 8'd1, 2'b01}); measure(400, iv);
        check(iv == P1, "R2 code 01", iv, P1);
        send_cfg({5'd0, 8'd1, 2'b10}); measure(400, iv);
        check(iv == P2, "R2 code 10", iv, P2);
        send_cfg({5'd0, 8'd1, 2'b11}); measure(400, iv);
        check(iv == P3, "R2 code 11", iv, P3);
        send_cfg({5'd0, 8'd1, 2'b00}); measure(400, iv);
        check(iv == P0, "R2 code 00", iv, P0);
    endtask

    task automatic t_ext_on;
        bit ok; int t0, iv;
        ext_en = 1;
        for (int i = 0; i < 400 && !src_ext; i++) @(negedge clk);
        check(src_ext == 1, "R1 source switches to external", src_ext, 1);
        check(sample_tick == 1, "R10 switch in tick cycle", sample_tick, 1);
        t0 = cyc;
        @(negedge clk);
        check(sample_tick == 0, "R9 single-cycle pulse", sample_tick, 0);
        wait_tick(200, ok);
        iv = cyc - t0;
        check(ok && iv >= (BASE - 1) * EXT_CYC && iv <= BASE * EXT_CYC + 1,
              "R10 first external tick full length", iv, BASE * EXT_CYC);
        measure(400, iv);
        check(iv == BASE * EXT_CYC, "R3 N=1 spacing", iv, BASE * EXT_CYC);
    endtask

    task automatic t_ratios;
        int iv;
        send_cfg({5'd0, 8'd3, 2'b00}); measure(1000, iv);
        check(iv == 3 * BASE * EXT_CYC, "R3 N=3 spacing", iv, 3 * BASE * EXT_CYC);
        send_cfg({5'd0, 8'd0, 2'b00}); measure(10000, iv);
        check(iv == 256 * BASE * EXT_CYC, "R4 field 0 spacing", iv, 256 * BASE * EXT_CYC);
        send_cfg({5'd0, 8'd3, 2'b00}); measure(1000, iv);
        check(iv == 3 * BASE * EXT_CYC, "R3 N=3 restored", iv, 3 * BASE * EXT_CYC);
    endtask

    task automatic t_reject;
        int iv;
        send_cfg({5'd0, 8'd2, 2'b01}); measure(1000, iv);
        check(iv == 3 * BASE * EXT_CYC, "R5 field 2 ignored", iv, 3 * BASE * EXT_CYC);
        send_cfg({5'd1, 8'd1, 2'b00}); measure(1000, iv);
        check(iv == 3 * BASE * EXT_CYC, "R6 upper bits set ignored", iv, 3 * BASE * EXT_CYC);
        send_cfg({5'd0, 8'd1, 2'b00}); measure(400, iv);
        check(iv == BASE * EXT_CYC, "R3 N=1 after rejects", iv, BASE * EXT_CYC);
    endtask

    task automatic t_loss;
        bit ok; int t0, iv;
        wait_tick(400, ok);
        t0 = cyc;
        ext_en = 0;
        wait_tick(600, ok);
        iv = cyc - t0;
        check(src_ext == 0, "R8 source back to internal", src_ext, 0);
        check(ok && iv >= TMO + P0 && iv <= TMO + P0 + 40,
              "R8 gap across loss", iv, TMO + P0);
        measure(400, iv);
        check(iv == P0, "R8 internal period resumes", iv, P0);
    endtask

    task automatic finish_run;
        if (done) return;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(150000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_rates();
        t_ext_on();
        t_ratios();
        t_reject();
        t_loss();
        finish_run();
    end
endmodule